// File: doc/BRIEF.md
# Page-Mode ROM Read Sequencer

This block connects a synchronous host to an asynchronous parallel mask ROM that reads faster inside an open page. The host issues one read at a time over a ready/valid handshake. The request carries a byte address and a flag that selects byte or word width. The block then drives the ROM address pins, the active-low chip and output enables, and the width-select pin. It holds them for a counted number of clock cycles, samples the 16-bit data pins and returns the result as a single-cycle response pulse.

A page is eight consecutive words. The block remembers the page and the width of the last completed read while the chip stays enabled. When a new read targets the same page in the same width, it waits only the short in-page time. Any other read pays the full random-access time. This includes a read to a different page, a read after a width change, and the first read after standby. All wait counts come from picosecond timing parameters and the clock period: the ceiling of the quotient plus one margin cycle.

When no request arrives for a programmable number of idle cycles, chip enable is released and the ROM drops to standby. A bus-free flag rises only after output enable has been high long enough for the data pins to float.

Top module: `prom_page_reader`

## Requirements
- R1: While reset is high and in the cycle after it, `rom_ce_n`=1, `rom_oe_n`=1, `req_ready`=1, `rsp_valid`=0, `rom_bus_free`=1, `rom_word_sel`=1 and `rom_addr`=0.
- R2: A read that is not an in-page hit raises `rsp_valid` after the RAND_WAIT-th rising edge that follows the accepting edge. With the default parameters RAND_WAIT = ceil(100 ns / 10 ns) + 1 = 11.
- R3: A read is an in-page hit when chip enable is still active and the stored page is valid. It also needs the same width mode and equal word-address bits [19:3]. A hit takes HIT_WAIT = max(ceil(30/10)+1, ceil(30/10)+1) = 4 edges.
- R4: Changing any of word-address bits [19:3] forces the full random wait.
- R5: A read whose width mode differs from the previous read forces the full random wait, even within the same page.
- R6: In word mode (`req_byte`=0), `rom_addr` carries `req_addr[19:0]` and `rom_word_sel`=1. `rsp_data` returns all 16 data pins.
- R7: In byte mode (`req_byte`=1), `rom_addr` carries `req_addr[20:1]`, `rom_addr_lsb` carries `req_addr[0]` and `rom_word_sel`=0. `rsp_data` is {8'h00, data pins [7:0]}.
- R8: `req_ready` falls in the cycle after acceptance and rises in the same cycle as the single-cycle `rsp_valid` pulse.
- R9: While a read is in flight, both `rom_ce_n` and `rom_oe_n` are low. `rom_oe_n` returns high on the sampling edge.
- R10: After IDLE_CYC (default 8) consecutive idle cycles with no request, `rom_ce_n` goes high and the open page is forgotten. `rom_oe_n` is never low while `rom_ce_n` is high.
- R11: `rom_bus_free` is low while `rom_oe_n` is low. It rises FLOAT_WAIT = ceil(20/10)+1 = 3 cycles after `rom_oe_n` rises, provided no new read starts in between.
- R12: `rom_addr` does not change while a read is in flight, so sampling completes before the address moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host read request |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 21 | Byte address (word address in bits [19:0] for word mode) |
| req_byte | input | 1 | 1 = byte-width read, 0 = word-width read |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_data | output | 16 | Read data |
| rom_addr | output | 20 | ROM word address pins |
| rom_addr_lsb | output | 1 | Byte-select address bit (shared top data pin in byte mode) |
| rom_ce_n | output | 1 | Chip enable, active low |
| rom_oe_n | output | 1 | Output enable, active low |
| rom_word_sel | output | 1 | 1 = word width, 0 = byte width |
| rom_dq | input | 16 | ROM data pins |
| rom_bus_free | output | 1 | Data pins have floated since the last read |

## Verification
The bench's ROM model returns a garbage pattern until the address has been stable for the random or in-page time and output enable has been low for its time. A sequencer that waits too little, or that grants the short wait after a page, width or standby change, therefore returns wrong data. It also misses the latency the reference model predicts. The sequence covers the first word of a page and the last word of a page, the step into the next page, and a width switch inside one page. It also covers an idle gap long enough to enter standby, followed by a read to the same page, and the top byte and word addresses. A design that kept the upper byte lane in byte mode, or moved the address early, fails the per-cycle comparison.

// File: rtl/prom_pkg.sv
package prom_pkg;

  // Whole clock cycles covering t_ps, plus one margin cycle for synchronisation
  function automatic int unsigned wait_cycles(input int unsigned t_ps,
                                              input int unsigned clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps + 1;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  typedef enum logic [0:0] {
    RD_IDLE = 1'b0,
    RD_WAIT = 1'b1
  } rd_state_e;

endpackage

// File: rtl/prom_down_counter.sv
module prom_down_counter #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         is_one
);

  logic [W-1:0] count;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (dec && (count != '0)) begin
      count <= count - 1'b1;
    end
  end

  assign is_one = (count == W'(1));

endmodule

// File: rtl/prom_page_tracker.sv
module prom_page_tracker #(
  parameter int unsigned TAG_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TAG_W-1:0] lookup_tag,
  input  logic             lookup_byte,
  input  logic             fill,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             fill_byte,
  input  logic             flush,
  output logic             hit
);

  logic             open_q;
  logic [TAG_W-1:0] tag_q;
  logic             byte_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      tag_q  <= '0;
      byte_q <= 1'b0;
    end else if (flush) begin
      open_q <= 1'b0;
    end else if (fill) begin
      open_q <= 1'b1;
      tag_q  <= fill_tag;
      byte_q <= fill_byte;
    end
  end

  assign hit = open_q && (tag_q == lookup_tag) && (byte_q == lookup_byte);

endmodule

// File: rtl/prom_page_reader.sv
module prom_page_reader #(
  parameter int unsigned CLK_PS     = 10000,
  parameter int unsigned T_RAND_PS  = 100000,
  parameter int unsigned T_PAGE_PS  = 30000,
  parameter int unsigned T_OE_PS    = 30000,
  parameter int unsigned T_FLOAT_PS = 20000,
  parameter int unsigned IDLE_CYC   = 8,
  parameter int unsigned WADDR_W    = 20,
  parameter int unsigned PAGE_W     = 3,
  parameter int unsigned DATA_W     = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [WADDR_W:0]   req_addr,
  input  logic               req_byte,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data,
  output logic [WADDR_W-1:0] rom_addr,
  output logic               rom_addr_lsb,
  output logic               rom_ce_n,
  output logic               rom_oe_n,
  output logic               rom_word_sel,
  input  logic [DATA_W-1:0]  rom_dq,
  output logic               rom_bus_free
);

  import prom_pkg::*;

  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned LANES      = DATA_W / BYTE_W;
  localparam int unsigned TAG_W      = WADDR_W - PAGE_W;
  localparam int unsigned RAND_WAIT  = wait_cycles(T_RAND_PS, CLK_PS);
  localparam int unsigned PAGE_WAIT  = wait_cycles(T_PAGE_PS, CLK_PS);
  localparam int unsigned OE_WAIT    = wait_cycles(T_OE_PS, CLK_PS);
  localparam int unsigned HIT_WAIT   = max_u(PAGE_WAIT, OE_WAIT);
  localparam int unsigned FLOAT_WAIT = wait_cycles(T_FLOAT_PS, CLK_PS);
  localparam int unsigned ACC_W      = $clog2(max_u(RAND_WAIT, HIT_WAIT) + 1);
  localparam int unsigned IDLE_W     = $clog2(IDLE_CYC + 1);
  localparam int unsigned FLT_W      = $clog2(FLOAT_WAIT + 1);

  rd_state_e state_q;

  logic               ready_q;
  logic               rsp_valid_q;
  logic [DATA_W-1:0]  rsp_data_q;
  logic [WADDR_W-1:0] addr_q;
  logic               lsb_q;
  logic               ce_n_q;
  logic               oe_n_q;
  logic               word_sel_q;
  logic               bus_free_q;

  logic               accept;
  logic               capture;
  logic               go_standby;
  logic               page_hit;
  logic [WADDR_W-1:0] req_waddr;
  logic [TAG_W-1:0]   req_tag;
  logic               acc_last;
  logic               idle_last;
  logic               flt_last;
  logic [ACC_W-1:0]   acc_load;
  logic [DATA_W-1:0]  cap_data;

  // Request decode: word address and page tag for either width
  assign req_waddr = req_byte ? req_addr[WADDR_W:1] : req_addr[WADDR_W-1:0];
  assign req_tag   = req_waddr[WADDR_W-1:PAGE_W];

  assign accept     = ready_q && req_valid;
  assign capture    = (state_q == RD_WAIT) && acc_last;
  assign go_standby = (state_q == RD_IDLE) && !ce_n_q && !accept && idle_last;
  assign acc_load   = page_hit ? ACC_W'(HIT_WAIT) : ACC_W'(RAND_WAIT);

  prom_page_tracker #(
    .TAG_W (TAG_W)
  ) u_page (
    .clk         (clk),
    .rst         (rst),
    .lookup_tag  (req_tag),
    .lookup_byte (req_byte),
    .fill        (capture),
    .fill_tag    (addr_q[WADDR_W-1:PAGE_W]),
    .fill_byte   (!word_sel_q),
    .flush       (go_standby),
    .hit         (page_hit)
  );

  // Access timer: address and enables held for the loaded number of edges
  prom_down_counter #(
    .W (ACC_W)
  ) u_acc_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (acc_load),
    .dec      (state_q == RD_WAIT),
    .is_one   (acc_last)
  );

  // Idle timer: counts quiet cycles with the chip enabled
  prom_down_counter #(
    .W (IDLE_W)
  ) u_idle_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (capture),
    .load_val (IDLE_W'(IDLE_CYC)),
    .dec      ((state_q == RD_IDLE) && !ce_n_q && !accept),
    .is_one   (idle_last)
  );

  // Float timer: data pins released after output enable rises
  prom_down_counter #(
    .W (FLT_W)
  ) u_flt_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (capture),
    .load_val (FLT_W'(FLOAT_WAIT)),
    .dec      (1'b1),
    .is_one   (flt_last)
  );

  // Lane selection: byte mode keeps only the lowest lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_low
      assign cap_data[g*BYTE_W +: BYTE_W] = rom_dq[g*BYTE_W +: BYTE_W];
    end else begin : g_high
      assign cap_data[g*BYTE_W +: BYTE_W] =
        word_sel_q ? rom_dq[g*BYTE_W +: BYTE_W] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= RD_IDLE;
      ready_q     <= 1'b1;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      addr_q      <= '0;
      lsb_q       <= 1'b0;
      ce_n_q      <= 1'b1;
      oe_n_q      <= 1'b1;
      word_sel_q  <= 1'b1;
      bus_free_q  <= 1'b1;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        RD_IDLE: begin
          if (accept) begin
            state_q    <= RD_WAIT;
            ready_q    <= 1'b0;
            addr_q     <= req_waddr;
            lsb_q      <= req_byte & req_addr[0];
            word_sel_q <= !req_byte;
            ce_n_q     <= 1'b0;
            oe_n_q     <= 1'b0;
            bus_free_q <= 1'b0;
          end else begin
            if (go_standby) begin
              ce_n_q <= 1'b1;
            end
            if (flt_last) begin
              bus_free_q <= 1'b1;
            end
          end
        end
        RD_WAIT: begin
          if (capture) begin
            state_q     <= RD_IDLE;
            ready_q     <= 1'b1;
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= cap_data;
            oe_n_q      <= 1'b1;
          end
        end
        default: state_q <= RD_IDLE;
      endcase
    end
  end

  assign req_ready    = ready_q;
  assign rsp_valid    = rsp_valid_q;
  assign rsp_data     = rsp_data_q;
  assign rom_addr     = addr_q;
  assign rom_addr_lsb = lsb_q;
  assign rom_ce_n     = ce_n_q;
  assign rom_oe_n     = oe_n_q;
  assign rom_word_sel = word_sel_q;
  assign rom_bus_free = bus_free_q;

endmodule

// File: rtl/prom_page_reader_chk.sv
module prom_page_reader_chk #(
  parameter int unsigned WADDR_W = 20,
  parameter int unsigned HI_W    = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic [HI_W-1:0]    rsp_hi,
  input logic [WADDR_W-1:0] rom_addr,
  input logic               rom_ce_n,
  input logic               rom_oe_n,
  input logic               rom_word_sel,
  input logic               rom_bus_free
);

  assert_ready_with_valid_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> req_ready);

  assert_valid_single_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_enables_in_flight_R9: assert property (@(posedge clk) disable iff (rst)
    !req_ready |-> (!rom_ce_n && !rom_oe_n));

  assert_oe_needs_ce_R10: assert property (@(posedge clk) disable iff (rst)
    rom_ce_n |-> rom_oe_n);

  assert_bus_busy_R11: assert property (@(posedge clk) disable iff (rst)
    !rom_oe_n |-> !rom_bus_free);

  assert_addr_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && $past(!req_ready)) |-> $stable(rom_addr));

  assert_byte_upper_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rom_word_sel) |-> (rsp_hi == '0));

endmodule

bind prom_page_reader prom_page_reader_chk #(
  .WADDR_W (WADDR_W),
  .HI_W    (DATA_W - 8)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_hi       (rsp_data[DATA_W-1:8]),
  .rom_addr     (rom_addr),
  .rom_ce_n     (rom_ce_n),
  .rom_oe_n     (rom_oe_n),
  .rom_word_sel (rom_word_sel),
  .rom_bus_free (rom_bus_free)
);

// File: tb/test_prom_page_reader.sv
`timescale 1ns/1ps
module test_prom_page_reader;

  localparam int CLK_NS   = 10;
  localparam int RAND     = (100 + CLK_NS - 1) / CLK_NS + 1;
  localparam int HIT      = (30 + CLK_NS - 1) / CLK_NS + 1;
  localparam int FLT      = (20 + CLK_NS - 1) / CLK_NS + 1;
  localparam int IDLE     = 8;
  localparam int NEED_R   = 100 / CLK_NS;
  localparam int NEED_P   = 30 / CLK_NS;
  localparam int NEED_OE  = 30 / CLK_NS;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [20:0] req_addr = '0;
  logic        req_byte = 1'b0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic [19:0] rom_addr;
  logic        rom_addr_lsb;
  logic        rom_ce_n;
  logic        rom_oe_n;
  logic        rom_word_sel;
  logic [15:0] rom_dq = 16'hFFFF;
  logic        rom_bus_free;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_NS/2) clk = ~clk;

  prom_page_reader i_prom_page_reader (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_byte(req_byte), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rom_addr(rom_addr), .rom_addr_lsb(rom_addr_lsb),
    .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n), .rom_word_sel(rom_word_sel),
    .rom_dq(rom_dq), .rom_bus_free(rom_bus_free)
  );

  function automatic logic [15:0] rom_word(input logic [19:0] w);
    return (w[15:0] * 16'd3) ^ {w[19:16], 4'hC, w[3:0] ^ w[19:16], 4'h5};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // ---------------- ROM device model (timing-aware) ----------------
  logic [20:0] r_last_addr = '0;
  logic        r_last_ws   = 1'b1;
  int          r_addr_age  = 0;
  int          r_oe_age    = 0;
  logic        r_open      = 1'b0;
  logic [16:0] r_open_tag  = '0;

  always @(negedge clk) begin
    logic [15:0] w;
    int need;
    if ({rom_addr, rom_addr_lsb} != r_last_addr) r_addr_age = 0;
    else r_addr_age++;
    r_last_addr = {rom_addr, rom_addr_lsb};
    if (rom_oe_n) r_oe_age = -1; else r_oe_age++;
    if (rom_ce_n || rom_word_sel != r_last_ws) r_open = 1'b0;
    r_last_ws = rom_word_sel;
    need = (r_open && r_open_tag == rom_addr[19:3]) ? NEED_P : NEED_R;
    if (rom_ce_n || rom_oe_n) begin
      rom_dq = 16'hFFFF;
    end else if ((r_addr_age + 1) >= need && (r_oe_age + 1) >= NEED_OE) begin
      w = rom_word(rom_addr);
      if (rom_word_sel) rom_dq = w;
      else rom_dq = {8'hA5, rom_addr_lsb ? w[15:8] : w[7:0]};
      r_open = 1'b1;
      r_open_tag = rom_addr[19:3];
    end else begin
      rom_dq = 16'h0BAD;
    end
  end

  // ---------------- Cycle reference model ----------------
  logic        m_ready, m_rv, m_ce, m_oe, m_free, m_ws, m_lsb, m_pv, m_mode, m_cur_byte;
  logic [19:0] m_raddr;
  logic [16:0] m_tag;
  logic [15:0] m_exp, m_data;
  int          m_left, m_idle, m_flt;
  logic        hit_v;
  logic [19:0] wa_v;
  logic [15:0] w_v;

  always @(posedge clk) begin
    if (rst) begin
      m_ready <= 1; m_rv <= 0; m_ce <= 0; m_oe <= 0; m_free <= 1; m_ws <= 1;
      m_lsb <= 0; m_pv <= 0; m_mode <= 0; m_cur_byte <= 0; m_raddr <= '0;
      m_tag <= '0; m_exp <= '0; m_data <= '0; m_left <= 0; m_idle <= 0; m_flt <= 0;
    end else begin
      m_rv <= 0;
      if (m_flt > 0) m_flt <= m_flt - 1;
      if (m_ready && req_valid) begin
        wa_v  = req_byte ? req_addr[20:1] : req_addr[19:0];
        hit_v = m_pv && (wa_v[19:3] == m_tag) && (req_byte == m_mode);
        w_v   = rom_word(wa_v);
        m_left <= hit_v ? HIT : RAND;
        m_ready <= 0; m_ce <= 1; m_oe <= 1; m_free <= 0;
        m_raddr <= wa_v; m_lsb <= req_byte & req_addr[0];
        m_ws <= !req_byte; m_cur_byte <= req_byte;
        m_exp <= req_byte ? {8'h00, req_addr[0] ? w_v[15:8] : w_v[7:0]} : w_v;
      end else if (!m_ready) begin
        if (m_left == 1) begin
          m_rv <= 1; m_ready <= 1; m_oe <= 0; m_pv <= 1;
          m_tag <= m_raddr[19:3]; m_mode <= m_cur_byte;
          m_idle <= IDLE; m_flt <= FLT; m_data <= m_exp;
        end else m_left <= m_left - 1;
      end else begin
        if (m_ce && m_idle == 1) begin m_ce <= 0; m_pv <= 0; end
        if (m_ce && m_idle > 0) m_idle <= m_idle - 1;
        if (m_flt == 1) m_free <= 1;
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check(req_ready == m_ready, "R8 ready", req_ready, m_ready);
      check(rsp_valid == m_rv, "R2/R3 rsp_valid", rsp_valid, m_rv);
      if (m_rv)
        check(rsp_data == m_data, m_ws ? "R6 data" : "R7 data", rsp_data, m_data);
      check(rom_ce_n == !m_ce, "R10 ce_n", rom_ce_n, !m_ce);
      check(rom_oe_n == !m_oe, "R9 oe_n", rom_oe_n, !m_oe);
      check(rom_bus_free == m_free, "R11 bus_free", rom_bus_free, m_free);
      check(rom_word_sel == m_ws, "R6 word_sel", rom_word_sel, m_ws);
      check(rom_addr == m_raddr, "R12 rom_addr", rom_addr, m_raddr);
      check(rom_addr_lsb == m_lsb, "R7 addr_lsb", rom_addr_lsb, m_lsb);
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic do_req(input logic [20:0] a, input logic b, input int lat, input string tag);
    int n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_byte = b;
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
    check((n - 1) == lat, tag, n - 1, lat);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1 reset values
    check(rom_ce_n == 1 && rom_oe_n == 1, "R1 enables", {rom_ce_n, rom_oe_n}, 2'b11);
    check(req_ready == 1 && rsp_valid == 0, "R1 handshake", {req_ready, rsp_valid}, 2'b10);
    check(rom_bus_free == 1 && rom_word_sel == 1 && rom_addr == 0, "R1 pins",
          {rom_bus_free, rom_word_sel, rom_addr}, {2'b11, 20'h0});
    rst = 1'b0;
    @(negedge clk);
    check(rom_ce_n == 1 && req_ready == 1, "R1 after reset", {rom_ce_n, req_ready}, 2'b11);

    do_req(21'h00010, 1'b0, RAND, "R2 first read random");
    do_req(21'h00013, 1'b0, HIT,  "R3 in-page hit");
    do_req(21'h00017, 1'b0, HIT,  "R3 last word of page");
    do_req(21'h00018, 1'b0, RAND, "R4 next page");
    do_req(21'h00031, 1'b1, RAND, "R5 width switch same page");
    do_req(21'h00030, 1'b1, HIT,  "R7 byte in-page hit");
    do_req(21'h0001A, 1'b0, RAND, "R5 back to word");
    repeat (IDLE + 3) @(negedge clk);
    check(rom_ce_n == 1, "R10 standby after idle", rom_ce_n, 1);
    check(rom_bus_free == 1, "R11 bus free when idle", rom_bus_free, 1);
    do_req(21'h0001B, 1'b0, RAND, "R10 wake forces random");
    do_req(21'h1FFFFF, 1'b1, RAND, "R7 top byte address");
    do_req(21'h0FFFFF, 1'b0, RAND, "R6 top word address");
    do_req(21'h0FFFF8, 1'b0, HIT,  "R3 page start hit");
    do_req(21'h12345, 1'b0, RAND, "R4 far page");
    repeat (6) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule